// File: doc/BRIEF.md
# Comma Aligner with Receive Symbol Synchronisation

This block sits right after a deserialiser. Each clock it takes one raw 10-bit word whose bit boundaries need not match the 8B/10B character boundaries. It places the previous word and the current word side by side to form a 20-bit window. It then tests all ten candidate 10-bit slices that start inside the older word for a comma prefix. Once it has found a boundary, it sends out properly framed 10-bit symbols together with a valid strobe and a start-of-character marker.

A four-state controller manages the alignment:

- **Wait-for-lock:** the controller stays here while clock recovery reports no lock.
- **Search:** the controller scans for a comma.
- **Confirm:** the controller counts consecutive symbols that the downstream decoder accepts.
- **Locked:** the sync output is high in this state only.

The decoder returns a per-symbol invalid flag in the same cycle as the symbol it judges. A bad symbol while locked sends the controller back to confirmation. If that recheck then fails, the block reports a one-cycle loss-of-sync pulse and goes back to searching.

Top module: `comma_sync_top`

## Requirements
- R1: Bit order and slices. Raw word bit 9 is the earliest serial bit. The previous word is the older half of the window. For any of the ten bit offsets between the serial stream and the word boundaries, once aligned, the output symbol shown after the clock edge that took in raw word j equals the transmitted character j-1.
- R2: Comma pattern and priority. A comma is the earliest seven bits of a slice, reading from slice bit 9 downward, equal to 0011111 or 1100000. When several offsets in one window match, the lowest offset (the earliest start in the stream) is used.
- R3: `startOfChar` is high exactly when a valid output symbol begins with a comma.
- R4: While `lockIn` is low, the state returns to wait-for-lock. `syncOk` and `symValid` are low one edge later. The block moves to the search state on the first edge at which lock is high again.
- R5: In the search state no symbol is marked valid. The comma character itself is the first valid symbol, and it is emitted on the same edge on which the new offset is latched.
- R6: Four consecutive accepted symbols in confirmation, with the comma counted as the first, raise `syncOk`. An invalid symbol before the fourth returns to search and raises no loss-of-sync pulse.
- R7: An invalid symbol while locked drops `syncOk` and re-enters confirmation. Four accepted symbols restore `syncOk`.
- R8: An invalid symbol during a confirmation entered from the locked state raises `lostSync` for exactly one cycle and returns to search.
- R9: The offset changes only in the search state. A comma at another offset that arrives while locked does not disturb the aligned output.
- R10: While reset is held, `syncOk`, `symValid`, `lostSync` and `startOfChar` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rawWord | input | 10 | Unaligned word from the deserialiser, bit 9 earliest |
| lockIn | input | 1 | Clock recovery lock indication |
| invalidSym | input | 1 | Decoder verdict on the current `symOut` |
| symOut | output | 10 | Aligned symbol |
| symValid | output | 1 | `symOut` is a framed symbol |
| startOfChar | output | 1 | `symOut` begins with a comma |
| syncOk | output | 1 | Link is symbol-synchronised |
| lostSync | output | 1 | One-cycle pulse when a recheck fails |

## Verification
A wrong latched offset shows up on the first valid symbol: every later symbol is a rotated copy of the transmitted character, and the decoder model rejects it one edge later. A miscounted confirmation run moves the rising or falling edge of `syncOk` by a whole symbol relative to the scripted invalid characters. A lost recheck flag either removes or adds the `lostSync` pulse on the single edge after the second failure. The bench runs the whole scripted stream at each of the ten bit offsets and compares every port on every cycle, so any of these faults appears within one symbol of its cause.

// File: rtl/commasync_pkg.sv
package commasync_pkg;

  typedef enum logic [1:0] {
    ST_BITSYNC = 2'd0,
    ST_REALIGN = 2'd1,
    ST_CHECK   = 2'd2,
    ST_READY   = 2'd3
  } syncState_t;

  // strobes from the controller to the datapath
  typedef struct packed {
    logic loadOffset;
    logic emitValid;
  } alignCtl_t;

endpackage

// File: rtl/comma_scan.sv
module comma_scan #(
  parameter int SYM_W   = 10,
  parameter int COMMA_W = 7,
  parameter int OFF_W   = 4
) (
  input  logic [2*SYM_W-1:0] window,
  output logic [SYM_W-1:0]   slices [SYM_W],
  output logic [SYM_W-1:0]   hits,
  output logic               anyHit,
  output logic [OFF_W-1:0]   firstHit
);

  localparam logic [COMMA_W-1:0] PLUS_PAT  = {2'b00, {(COMMA_W-2){1'b1}}};
  localparam logic [COMMA_W-1:0] MINUS_PAT = ~PLUS_PAT;

  // one candidate slice per bit offset; offset k starts k bits into the older word
  for (genvar k = 0; k < SYM_W; k++) begin : g_off
    assign slices[k] = window[2*SYM_W-1-k -: SYM_W];
    assign hits[k]   = (slices[k][SYM_W-1 -: COMMA_W] == PLUS_PAT) ||
                       (slices[k][SYM_W-1 -: COMMA_W] == MINUS_PAT);
  end

  assign anyHit = |hits;

  // lowest offset has priority
  always_comb begin
    firstHit = '0;
    for (int k = SYM_W - 1; k >= 0; k--) begin
      if (hits[k]) firstHit = OFF_W'(k);
    end
  end

endmodule

// File: rtl/commasync_datapath.sv
module commasync_datapath
  import commasync_pkg::*;
#(
  parameter int SYM_W   = 10,
  parameter int COMMA_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SYM_W-1:0] rawWord,
  input  alignCtl_t        ctl,
  output logic             commaFound,
  output logic [SYM_W-1:0] symOut,
  output logic             symValid,
  output logic             startOfChar
);

  localparam int OFF_W = $clog2(SYM_W);

  logic [SYM_W-1:0]   prevWord;
  logic [OFF_W-1:0]   offsetReg;
  logic [OFF_W-1:0]   firstHit;
  logic [OFF_W-1:0]   curOffset;
  logic [SYM_W-1:0]   slices [SYM_W];
  logic [SYM_W-1:0]   hits;
  logic [2*SYM_W-1:0] window;

  assign window = {prevWord, rawWord};

  comma_scan #(
    .SYM_W  (SYM_W),
    .COMMA_W(COMMA_W),
    .OFF_W  (OFF_W)
  ) u_scan (
    .window  (window),
    .slices  (slices),
    .hits    (hits),
    .anyHit  (commaFound),
    .firstHit(firstHit)
  );

  // the comma symbol itself uses the freshly found offset
  assign curOffset = ctl.loadOffset ? firstHit : offsetReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevWord    <= '0;
      offsetReg   <= '0;
      symOut      <= '0;
      symValid    <= 1'b0;
      startOfChar <= 1'b0;
    end else begin
      prevWord    <= rawWord;
      if (ctl.loadOffset) offsetReg <= firstHit;
      symOut      <= slices[curOffset];
      symValid    <= ctl.emitValid;
      startOfChar <= ctl.emitValid && hits[curOffset];
    end
  end

  // R9: offset moves only on a load strobe
  p_offset_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.loadOffset |=> $stable(offsetReg));

  // R3: marker never without a valid symbol
  p_soc_valid_r3: assert property (@(posedge clk) disable iff (!rstN)
    startOfChar |-> symValid);

  // R5: a load always produces a valid comma symbol on the next cycle
  p_load_emits_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadOffset |=> (symValid && startOfChar));

endmodule

// File: rtl/commasync_ctrl.sv
module commasync_ctrl
  import commasync_pkg::*;
#(
  parameter int CONFIRM_RUN = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      lockIn,
  input  logic      invalidSym,
  input  logic      commaFound,
  input  logic      symValid,
  output alignCtl_t ctl,
  output logic      syncOk,
  output logic      lostSync
);

  localparam int CNT_W = $clog2(CONFIRM_RUN + 1);

  syncState_t       state;
  logic [CNT_W-1:0] goodCnt;
  logic             recheck;

  assign ctl.loadOffset = lockIn && (state == ST_REALIGN) && commaFound;
  assign ctl.emitValid  = lockIn && ((state == ST_CHECK) || (state == ST_READY) ||
                                     ((state == ST_REALIGN) && commaFound));
  assign syncOk = (state == ST_READY);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_BITSYNC;
      goodCnt  <= '0;
      recheck  <= 1'b0;
      lostSync <= 1'b0;
    end else begin
      lostSync <= 1'b0;
      if (!lockIn) begin
        state   <= ST_BITSYNC;
        goodCnt <= '0;
        recheck <= 1'b0;
      end else begin
        unique case (state)
          ST_BITSYNC: state <= ST_REALIGN;
          ST_REALIGN: begin
            if (commaFound) begin
              state   <= ST_CHECK;
              goodCnt <= '0;
              recheck <= 1'b0;
            end
          end
          ST_CHECK: begin
            if (symValid) begin
              if (invalidSym) begin
                state    <= ST_REALIGN;
                goodCnt  <= '0;
                lostSync <= recheck;
                recheck  <= 1'b0;
              end else if (goodCnt == CNT_W'(CONFIRM_RUN - 1)) begin
                state   <= ST_READY;
                goodCnt <= '0;
                recheck <= 1'b0;
              end else begin
                goodCnt <= goodCnt + 1'b1;
              end
            end
          end
          ST_READY: begin
            if (symValid && invalidSym) begin
              state   <= ST_CHECK;
              goodCnt <= '0;
              recheck <= 1'b1;
            end
          end
          default: state <= ST_BITSYNC;
        endcase
      end
    end
  end

  // R4: no lock forces the wait state
  p_nolock_r4: assert property (@(posedge clk) disable iff (!rstN)
    !lockIn |=> (state == ST_BITSYNC));

  // R6: ready is reached only out of confirmation
  p_ready_entry_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncOk) |-> ($past(state) == ST_CHECK));

  // R8: loss pulse lasts one cycle
  p_lost_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    lostSync |=> !lostSync);

  // R8: loss pulse comes from a failed confirmation and lands in search
  p_lost_realign_r8: assert property (@(posedge clk) disable iff (!rstN)
    lostSync |-> ((state == ST_REALIGN) && ($past(state) == ST_CHECK)));

endmodule

// File: rtl/comma_sync_top.sv
module comma_sync_top
  import commasync_pkg::*;
#(
  parameter int SYM_W       = 10,
  parameter int COMMA_W     = 7,
  parameter int CONFIRM_RUN = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SYM_W-1:0] rawWord,
  input  logic             lockIn,
  input  logic             invalidSym,
  output logic [SYM_W-1:0] symOut,
  output logic             symValid,
  output logic             startOfChar,
  output logic             syncOk,
  output logic             lostSync
);

  alignCtl_t ctl;
  logic      commaFound;

  commasync_datapath #(
    .SYM_W  (SYM_W),
    .COMMA_W(COMMA_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .rawWord    (rawWord),
    .ctl        (ctl),
    .commaFound (commaFound),
    .symOut     (symOut),
    .symValid   (symValid),
    .startOfChar(startOfChar)
  );

  commasync_ctrl #(
    .CONFIRM_RUN(CONFIRM_RUN)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .lockIn    (lockIn),
    .invalidSym(invalidSym),
    .commaFound(commaFound),
    .symValid  (symValid),
    .ctl       (ctl),
    .syncOk    (syncOk),
    .lostSync  (lostSync)
  );

endmodule

// File: tb/comma_sync_top_test.sv
module comma_sync_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int LAST_WORD  = 85;

  localparam logic [9:0] KCOMMA = 10'b0011111010;
  localparam logic [9:0] DFILL  = 10'b1010101010;
  localparam logic [9:0] XCODE  = 10'b1010100011;
  localparam logic [9:0] YCODE  = 10'b1110101010;
  localparam logic [9:0] DBL    = 10'b0011111000;
  localparam logic [9:0] AFT    = 10'b0010101010;
  localparam logic [9:0] BAD    = 10'b1111111111;

  logic       clk = 1'b0;
  logic       rstN;
  logic [9:0] rawWord;
  logic       lockIn;
  logic       invalidSym;
  logic [9:0] symOut;
  logic       symValid, startOfChar, syncOk, lostSync;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  comma_sync_top uut (
    .clk(clk), .rstN(rstN), .rawWord(rawWord), .lockIn(lockIn),
    .invalidSym(invalidSym), .symOut(symOut), .symValid(symValid),
    .startOfChar(startOfChar), .syncOk(syncOk), .lostSync(lostSync)
  );

  // stand-in decoder: accepts only the codes the script uses as legal
  assign invalidSym = symValid &&
    !(symOut inside {KCOMMA, DFILL, XCODE, YCODE, DBL, AFT});

  function automatic logic [9:0] symAt(int m);
    case (m)
      3, 40, 70:   return KCOMMA;
      14:          return XCODE;
      15:          return YCODE;
      20, 30, 32, 63: return BAD;
      60:          return DBL;
      61:          return AFT;
      default:     return DFILL;
    endcase
  endfunction

  function automatic logic [9:0] wordAt(int j, int sh);
    logic [9:0] w;
    for (int i = 0; i < 10; i++) begin
      int n = 10*j + i;
      logic [9:0] c;
      if (n < sh) w[9-i] = n[0];
      else begin
        c = symAt((n - sh) / 10);
        w[9-i] = c[9 - ((n - sh) % 10)];
      end
    end
    return w;
  endfunction

  function automatic bit inR(int j, int a, int b);
    return (j >= a) && (j <= b);
  endfunction

  function automatic bit isComma(logic [9:0] c);
    return (c[9:3] == 7'b0011111) || (c[9:3] == 7'b1100000);
  endfunction

  task automatic check(bit ok, string req, int sh, int j, logic [9:0] act, logic [9:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s shift=%0d word=%0d actual=%b expected=%b", req, sh, j, act, exp);
    end
  endtask

  initial begin
    rstN = 1'b0; rawWord = '0; lockIn = 1'b0;
    for (int sh = 0; sh < 10; sh++) begin
      rstN = 1'b0; lockIn = 1'b0; rawWord = '0;
      repeat (2) @(negedge clk);
      // R10: state while reset is held
      check(!syncOk && !symValid && !lostSync && !startOfChar, "R10", sh, -1,
            {6'd0, syncOk, symValid, lostSync, startOfChar}, 10'd0);
      rstN = 1'b1;
      for (int j = 0; j <= LAST_WORD; j++) begin
        bit eValid, eSync, eLost, eSoc;
        logic [9:0] eSym;
        rawWord = wordAt(j, sh);
        lockIn  = !inR(j, 52, 54);
        @(negedge clk);
        eValid = inR(j, 4, 34) || inR(j, 41, 51) || inR(j, 61, 65) || inR(j, 71, LAST_WORD);
        eSync  = inR(j, 8, 21) || inR(j, 26, 31) || inR(j, 45, 51) || inR(j, 75, LAST_WORD);
        eLost  = (j == 34);
        eSym   = (j > 0) ? symAt(j - 1) : DFILL;
        eSoc   = eValid && isComma(eSym);
        // R4 covers the lock-drop window, R5 the search phases
        check(symValid == eValid, inR(j, 52, 55) ? "R4" : "R5", sh, j,
              {9'd0, symValid}, {9'd0, eValid});
        if (eValid)
          check(symOut == eSym, inR(j, 61, 65) ? "R2" : (inR(j, 14, 17) ? "R9" : "R1"),
                sh, j, symOut, eSym);
        // R6 first lock, R7 recovery after one bad symbol
        check(syncOk == eSync, inR(j, 20, 27) ? "R7" : "R6", sh, j,
              {9'd0, syncOk}, {9'd0, eSync});
        check(lostSync == eLost, "R8", sh, j, {9'd0, lostSync}, {9'd0, eLost});
        check(startOfChar == eSoc, "R3", sh, j, {9'd0, startOfChar}, {9'd0, eSoc});
      end
    end
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule